// File: doc/BRIEF.md
# Reset Supervisor with Debounced Manual Request

This block produces the chip-level reset from two causes. One cause is a digital "supply good" flag, which comes from an external voltage comparator. The other is an active-low manual reset request, which may come straight from a mechanical switch.

Reset is held for as long as either cause is active. After the last cause goes away, reset is stretched by a fixed number of clock cycles, so downstream logic always sees a long and clean reset. The block drives the reset twice: as an active-low level and as its active-high complement.

Both inputs pass through two-flop synchronizers. The manual level is then debounced: it only changes after the synchronized input has held its new value for a programmable number of consecutive clocks. The hold interval defaults to 200 ms and the debounce interval to 1 ms, both derived from the clock frequency parameter. The state registers power up with reset asserted and the hold counter loaded. The debounced manual level powers up high, so an input that has never been seen low counts as inactive, in the same way as a pulled-up pin.

Top module: `rst_supervisor`

## Requirements
- R1: At power-up `rst_n` is low. With `supply_ok` high and `mr_n` high from time zero, `rst_n` rises right after clock edge HOLD_CYCLES+2, counting the first edge as edge 0. The manual input counts as inactive until it has been seen low.
- R2: If `supply_ok` goes low, `rst_n` is low after the third clock edge that follows. It stays low for as long as `supply_ok` stays low.
- R3: After `supply_ok` returns high, with no other cause active, `rst_n` stays low through edge HOLD_CYCLES+1 and rises after edge HOLD_CYCLES+2. Edges are counted from edge 0, the first edge after the change.
- R4: If `mr_n` goes low and stays low, `rst_n` stays high through edge DEBOUNCE_CYCLES+1 and is low after edge DEBOUNCE_CYCLES+2.
- R5: After `mr_n` returns high and stays high, with no other cause active, `rst_n` stays low through edge DEBOUNCE_CYCLES+HOLD_CYCLES+1 and rises after edge DEBOUNCE_CYCLES+HOLD_CYCLES+2.
- R6: A low pulse on `mr_n` that lasts fewer than DEBOUNCE_CYCLES clocks has no effect: `rst_n` stays high.
- R7: If a cause returns while the hold is still running, the hold restarts. Its full length is then counted from the final release.
- R8: When both causes overlap, the hold is counted from whichever cause releases last.
- R9: `rst` is always the logical inverse of `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock at CLK_HZ |
| supply_ok | input | 1 | High while the supply is above threshold (asynchronous) |
| mr_n | input | 1 | Active-low manual reset request, raw switch allowed |
| rst_n | output | 1 | Active-low reset |
| rst | output | 1 | Active-high reset, inverse of `rst_n` |

## Verification
Every result appears a fixed number of edges after its stimulus. Supply changes reach the output after two synchronizer stages plus the output register. Manual changes also pass the debouncer, which adds DEBOUNCE_CYCLES edges. Every release adds HOLD_CYCLES more edges. The bench drives inputs one time unit after a rising edge, counts edges from the next one, and samples one time unit after the edge in question. Each timing requirement is checked on both sides of its boundary: at the last edge where the old value must still show, and at the first edge where the new one must appear.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int HOLD_CYCLES     = CLK_HZ / 5,
  parameter int DEBOUNCE_CYCLES = CLK_HZ / 1000
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic mr_n,
  output logic rst_n,
  output logic rst
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int DW = $clog2(DEBOUNCE_CYCLES + 1);

  logic          sup_s1 = 1'b0, sup_s2 = 1'b0;
  logic          mr_s1  = 1'b1, mr_s2  = 1'b1;
  logic          mr_db  = 1'b1;
  logic [DW-1:0] db_cnt = '0;
  logic [HW-1:0] hold_cnt = HW'(HOLD_CYCLES);
  logic          rst_n_q = 1'b0;
  logic          cause;

  always_ff @(posedge clk) begin
    sup_s1 <= supply_ok;
    sup_s2 <= sup_s1;
    mr_s1  <= mr_n;
    mr_s2  <= mr_s1;
  end

  always_ff @(posedge clk) begin
    if (mr_s2 == mr_db) begin
      db_cnt <= '0;
    end else if (db_cnt == DW'(DEBOUNCE_CYCLES - 1)) begin
      db_cnt <= '0;
      mr_db  <= mr_s2;
    end else begin
      db_cnt <= db_cnt + 1'b1;
    end
  end

  assign cause = !sup_s2 || !mr_db;

  always_ff @(posedge clk) begin
    if (cause)
      hold_cnt <= HW'(HOLD_CYCLES);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
    rst_n_q <= !cause && (hold_cnt == '0);
  end

  assign rst_n = rst_n_q;
  assign rst   = !rst_n_q;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int HOLD_CYCLES     = 10,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input logic clk,
  input logic cause,
  input logic mr_s2,
  input logic mr_db,
  input logic rst_n
);
  logic        started = 1'b0;
  logic [31:0] quiet = '0;
  logic [31:0] run = '0;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (cause) quiet <= '0;
    else if (quiet != 32'hFFFF_FFFF) quiet <= quiet + 1;
    run <= (mr_s2 != mr_db) ? run + 1 : '0;
  end

  p_cause_forces_reset_r2: assert property (@(posedge clk) disable iff (!started)
    cause |=> !rst_n);

  p_release_after_hold_r3: assert property (@(posedge clk) disable iff (!started)
    $rose(rst_n) |-> $past(quiet) == 32'(HOLD_CYCLES));

  p_debounce_window_r6: assert property (@(posedge clk) disable iff (!started)
    !$stable(mr_db) |-> $past(run) == 32'(DEBOUNCE_CYCLES - 1));

  p_debounce_level_r4: assert property (@(posedge clk) disable iff (!started)
    !$stable(mr_db) |-> mr_db == $past(mr_s2));

  p_no_spurious_reset_r7: assert property (@(posedge clk) disable iff (!started)
    (rst_n && !cause) |=> rst_n);
endmodule

bind rst_supervisor rst_supervisor_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
) chk (
  .clk(clk),
  .cause(cause),
  .mr_s2(mr_s2),
  .mr_db(mr_db),
  .rst_n(rst_n)
);

// File: tb/rst_supervisor_test.sv
`timescale 1ns/1ps
module rst_supervisor_test;
  localparam int HOLD = 40;
  localparam int DEB  = 8;

  logic clk = 1'b0;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic rst_n, rst;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.CLK_HZ(250_000_000), .HOLD_CYCLES(HOLD), .DEBOUNCE_CYCLES(DEB)) uut (
    .clk(clk), .supply_ok(supply_ok), .mr_n(mr_n), .rst_n(rst_n), .rst(rst)
  );

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic exp);
    checks++;
    if (rst_n !== exp) begin
      failures++;
      $display("FAIL %s: rst_n=%b expected %b", req, rst_n, exp);
    end
    checks++;
    if (rst !== !exp) begin
      failures++;
      $display("FAIL R9: rst=%b expected %b", rst, !exp);
    end
  endtask

  task automatic t_power_up;
    #1 check("R1 at time zero", 1'b0);
    edges(HOLD + 2); check("R1 before release", 1'b0);
    edges(1);        check("R1 after release", 1'b1);
  endtask

  task automatic t_supply;
    supply_ok = 1'b0;
    edges(3);  check("R2 supply fall", 1'b0);
    edges(20); check("R2 supply held low", 1'b0);
    supply_ok = 1'b1;
    edges(HOLD + 2); check("R3 before release", 1'b0);
    edges(1);        check("R3 after release", 1'b1);
  endtask

  task automatic t_manual;
    mr_n = 1'b0;
    edges(DEB + 2); check("R4 before debounce", 1'b1);
    edges(1);       check("R4 after debounce", 1'b0);
    edges(10);
    mr_n = 1'b1;
    edges(DEB + HOLD + 2); check("R5 before release", 1'b0);
    edges(1);              check("R5 after release", 1'b1);
  endtask

  task automatic t_glitch;
    int lows = 0;
    for (int k = 0; k < 3; k++) begin
      mr_n = 1'b0;
      for (int i = 0; i < DEB - 1; i++) begin edges(1); if (!rst_n) lows++; end
      mr_n = 1'b1;
      for (int i = 0; i < 3; i++) begin edges(1); if (!rst_n) lows++; end
    end
    for (int i = 0; i < DEB + HOLD + 5; i++) begin edges(1); if (!rst_n) lows++; end
    checks++;
    if (lows != 0) begin
      failures++;
      $display("FAIL R6: rst_n low on %0d samples expected 0", lows);
    end
    check("R6 glitch ignored", 1'b1);
  endtask

  task automatic t_reassert;
    supply_ok = 1'b0; edges(5);
    supply_ok = 1'b1; edges(HOLD / 2);
    check("R7 mid hold", 1'b0);
    supply_ok = 1'b0; edges(2);
    supply_ok = 1'b1;
    edges(HOLD + 2); check("R7 restarted hold before release", 1'b0);
    edges(1);        check("R7 restarted hold release", 1'b1);
  endtask

  task automatic t_overlap;
    supply_ok = 1'b0; edges(5);
    mr_n = 1'b0;      edges(DEB + 5);
    supply_ok = 1'b1; edges(HOLD + 10);
    check("R8 manual still active", 1'b0);
    mr_n = 1'b1;
    edges(DEB + HOLD + 2); check("R8 manual last before release", 1'b0);
    edges(1);              check("R8 manual last release", 1'b1);
    supply_ok = 1'b0; mr_n = 1'b0; edges(DEB + 5);
    mr_n = 1'b1;      edges(DEB + 5);
    supply_ok = 1'b1;
    edges(HOLD + 2); check("R8 supply last before release", 1'b0);
    edges(1);        check("R8 supply last release", 1'b1);
  endtask

  initial begin
    t_power_up();
    t_supply();
    t_manual();
    t_glitch();
    t_reassert();
    t_overlap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule